// File: doc/BRIEF.md
# Module Clock Gating and Power-State Controller

This block gates the clocks of a small set of peripheral modules, each of which belongs to one power domain. Software uses a single-cycle register port. It first writes the state it wants a module to reach into that module's control register. It then starts a transition by writing a one at the domain's bit in a command register. The new state does not take effect until that command arrives.

While a domain's transition runs, its bit in a status register reads one. After a fixed number of cycles the transition ends. At that point every module of the domain adopts the state last written to its control register, and the domain's power state follows its power-on request bit. Each module drives a clock-enable output and an active-high local-reset output. A separate clock-running bit in the module status register mirrors the clock enable, apart from the state field.

Module `m` belongs to domain `m mod NUM_DOM`. The per-index registers sit at a base offset plus four times the index.

Top module: `psc_ctrl`

## Requirements
- R1: After reset every module state reads 0 (software-reset-disable), every clock enable is 0, every local reset is 1, every domain status reads 0 (off) and the busy register at 0x128 reads 0.
- R2: A write to a module control register (0xA00 + 4·m) does not change that module's status register (0x800 + 4·m) or its clock enable until a transition of its domain completes.
- R3: Writing a 1 at bit N of 0x120 starts a transition of domain N. Bit N of 0x128 reads 1 in the BUSY_CYCLES cycles after the write edge and reads 0 from the BUSY_CYCLES-th edge on. Zero bits in the write start nothing.
- R4: When a transition of a domain completes, bits 5:0 of each of its modules' status equal bits 5:0 last written to that module's control register, including codes above 3. State codes: 0 software-reset-disable, 1 sync-reset, 2 disable, 3 enable.
- R5: A transition of one domain leaves the state of every module of the other domains unchanged.
- R6: A module's clock enable output and bit 12 of its status register are 1 exactly when its state is 3 (enable).
- R7: A module's local reset output is 1 when its state is 0 or 1, or when bit 8 of its control register is 0. The bit 8 part follows the control register from the edge after the write, without waiting for a transition.
- R8: A command write for a domain that is already busy is ignored: the transition still ends on its original cycle.
- R9: When a transition of domain N completes, bits 4:0 of the domain status register (0x200 + 4·N) read 1 if bit 0 of the domain control register (0x300 + 4·N) is set, and 0 if it is clear.
- R10: Reads of module control return bits 5:0, bit 8 and bit 31 as written, with all other bits 0. Reads of an unmapped offset return 0.
- R11: Module m is served by domain m mod NUM_DOM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| mod_clk_en | output | NUM_MOD | Clock enable per module |
| mod_lrst | output | NUM_MOD | Local reset per module, active high |

## Verification
Every cycle, the assertions check the transition counter. An accepted command makes the domain busy, a busy domain stays busy until its completion pulse, and a command during busy only lets the count fall by one. They also check that a module state moves only on its domain's completion pulse and then takes the requested value, that the domain power state changes only at completion, and that unmapped reads return zero. The exact busy length and where it ends can only be shown by the bench's scenarios. The same holds for the mapping of modules to domains, the isolation between domains, the encoding of the clock and reset outputs across all state and release combinations, and the read-back layout.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFF_GO    = 12'h120;
  localparam logic [AW-1:0] OFF_BUSY  = 12'h128;
  localparam logic [AW-1:0] OFF_DSTAT = 12'h200;
  localparam logic [AW-1:0] OFF_DCTL  = 12'h300;
  localparam logic [AW-1:0] OFF_MSTAT = 12'h800;
  localparam logic [AW-1:0] OFF_MCTL  = 12'hA00;

  localparam int ST_W = 6;
  localparam logic [ST_W-1:0] MST_RSTOFF  = 6'd0;
  localparam logic [ST_W-1:0] MST_SYNCRST = 6'd1;
  localparam logic [ST_W-1:0] MST_DISABLE = 6'd2;
  localparam logic [ST_W-1:0] MST_ENABLE  = 6'd3;

  localparam int REL_BIT   = 8;
  localparam int FORCE_BIT = 31;
  localparam int CLKON_BIT = 12;

  function automatic logic clk_running(input logic [ST_W-1:0] st);
    return st == MST_ENABLE;
  endfunction

  function automatic logic lrst_active(input logic [ST_W-1:0] st, input logic rel);
    return (st <= MST_SYNCRST) || !rel;
  endfunction

  function automatic int owner_domain(input int m, input int nd);
    return m % nd;
  endfunction

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base, input int idx);
    return base + AW'(4 * idx);
  endfunction
endpackage

// File: rtl/psc_domain_seq.sv
module psc_domain_seq #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic pwr_req,
  output logic busy,
  output logic done_pulse,
  output logic dom_on
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic go_accept;

  assign go_accept  = go_req && !busy;
  assign done_pulse = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      dom_on <= 1'b0;
    end else if (go_accept) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      if (done_pulse) begin
        busy   <= 1'b0;
        cnt    <= '0;
        dom_on <= pwr_req;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  a_r3_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> busy);
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_pulse) |=> busy);
  a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && busy && !done_pulse) |=> (cnt == $past(cnt) - CNT_W'(1)));
  a_r9_dom_update: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (dom_on == $past(pwr_req)));
  a_r9_dom_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> $stable(dom_on));
endmodule

// File: rtl/psc_module_slot.sv
module psc_module_slot
  import psc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  input  logic          apply,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] stat_q,
  output logic          clk_en,
  output logic          lrst
);
  logic [ST_W-1:0] nxt_st;
  logic [ST_W-1:0] cur_st;
  logic            rel;
  logic            force_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_st  <= MST_RSTOFF;
      rel     <= 1'b0;
      force_f <= 1'b0;
    end else if (ctl_we) begin
      nxt_st  <= wdata[ST_W-1:0];
      rel     <= wdata[REL_BIT];
      force_f <= wdata[FORCE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_st <= MST_RSTOFF;
    else if (apply) cur_st <= nxt_st;
  end

  assign clk_en = clk_running(cur_st);
  assign lrst   = lrst_active(cur_st, rel);

  always_comb begin
    ctl_q                = '0;
    ctl_q[ST_W-1:0]      = nxt_st;
    ctl_q[REL_BIT]       = rel;
    ctl_q[FORCE_BIT]     = force_f;
    stat_q               = '0;
    stat_q[ST_W-1:0]     = cur_st;
    stat_q[CLKON_BIT]    = clk_en;
  end

  a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(cur_st));
  a_r4_state_apply: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (cur_st == $past(nxt_st)));
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int NUM_MOD     = 4,
  parameter int NUM_DOM     = 2,
  parameter int BUSY_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_lrst
);
  logic               wr_en;
  logic               wr_go;
  logic [NUM_DOM-1:0] pwr_req;
  logic [NUM_DOM-1:0] dom_busy;
  logic [NUM_DOM-1:0] dom_done;
  logic [NUM_DOM-1:0] dom_on;
  logic [DW-1:0]      mctl_q [NUM_MOD];
  logic [DW-1:0]      mstat_q[NUM_MOD];
  logic               rd_hit;

  assign wr_en = bus_sel && bus_wr;
  assign wr_go = wr_en && (bus_addr == OFF_GO);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam logic [AW-1:0] DCTL_A = slot_addr(OFF_DCTL, d);

    always_ff @(posedge clk) begin
      if (!rst_n) pwr_req[d] <= 1'b0;
      else if (wr_en && bus_addr == DCTL_A) pwr_req[d] <= bus_wdata[0];
    end

    psc_domain_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_req    (wr_go && bus_wdata[d]),
      .pwr_req   (pwr_req[d]),
      .busy      (dom_busy[d]),
      .done_pulse(dom_done[d]),
      .dom_on    (dom_on[d])
    );
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam logic [AW-1:0] MCTL_A = slot_addr(OFF_MCTL, m);
    localparam int            OWNER  = owner_domain(m, NUM_DOM);

    psc_module_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_we (wr_en && bus_addr == MCTL_A),
      .wdata  (bus_wdata),
      .apply  (dom_done[OWNER]),
      .ctl_q  (mctl_q[m]),
      .stat_q (mstat_q[m]),
      .clk_en (mod_clk_en[m]),
      .lrst   (mod_lrst[m])
    );
  end

  always_comb begin
    bus_rdata = '0;
    rd_hit    = 1'b0;
    if (bus_addr == OFF_GO) begin
      rd_hit = 1'b1;
    end
    if (bus_addr == OFF_BUSY) begin
      rd_hit = 1'b1;
      bus_rdata[NUM_DOM-1:0] = dom_busy;
    end
    for (int d = 0; d < NUM_DOM; d++) begin
      if (bus_addr == slot_addr(OFF_DSTAT, d)) begin
        rd_hit    = 1'b1;
        bus_rdata = DW'(dom_on[d]);
      end
      if (bus_addr == slot_addr(OFF_DCTL, d)) begin
        rd_hit    = 1'b1;
        bus_rdata = DW'(pwr_req[d]);
      end
    end
    for (int m = 0; m < NUM_MOD; m++) begin
      if (bus_addr == slot_addr(OFF_MSTAT, m)) begin
        rd_hit    = 1'b1;
        bus_rdata = mstat_q[m];
      end
      if (bus_addr == slot_addr(OFF_MCTL, m)) begin
        rd_hit    = 1'b1;
        bus_rdata = mctl_q[m];
      end
    end
  end

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !rd_hit) |-> (bus_rdata == '0));
  a_r6_clk_bit_match: assert property (@(posedge clk) disable iff (!rst_n)
    mod_clk_en[0] == mstat_q[0][CLKON_BIT]);
endmodule

// File: tb/psc_ctrl_tb.sv
module psc_ctrl_tb;
  import psc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int ND = 2;
  localparam int BC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NM-1:0] mod_clk_en;
  logic [NM-1:0] mod_lrst;

  int n_chk = 0;
  int n_fail = 0;
  int exp_st [NM];
  int exp_nx [NM];
  int exp_rel[NM];

  psc_ctrl #(.NUM_MOD(NM), .NUM_DOM(ND), .BUSY_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_lrst(mod_lrst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] exp_stat(input int st);
    return 32'(st) | ((st == 3) ? 32'h1000 : 32'h0);
  endfunction

  task automatic check_mods(input string tag);
    logic [DW-1:0] v;
    logic [NM-1:0] ce, lr;
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      peek(OFF_MSTAT + 12'(4*m), v);
      chk(v, exp_stat(exp_st[m]), {tag, " R4/R6 status"});
      ce[m] = (exp_st[m] == 3);
      lr[m] = (exp_st[m] <= 1) || (exp_rel[m] == 0);
    end
    bus_sel = 1'b0;
    chk(32'(mod_clk_en), 32'(ce), {tag, " R6 clk_en"});
    chk(32'(mod_lrst), 32'(lr), {tag, " R7 lrst"});
  endtask

  task automatic write_ctl(input int m, input int st, input int rel, input bit frc);
    wr(OFF_MCTL + 12'(4*m), 32'(st) | (32'(rel) << 8) | (frc ? 32'h8000_0000 : 32'h0));
    exp_nx[m] = st; exp_rel[m] = rel;
  endtask

  task automatic run_go(input logic [31:0] dmask, input bit inject);
    logic [DW-1:0] v;
    wr(OFF_GO, dmask);
    for (int k = 0; k <= BC; k++) begin
      if (k > 0) @(posedge clk);
      @(negedge clk);
      peek(OFF_BUSY, v);
      chk(v, (k < BC) ? dmask : 32'h0, inject ? "R8 busy window" : "R3 busy window");
      if (inject && k == 3) begin
        bus_wr = 1'b1; bus_addr = OFF_GO; bus_wdata = dmask;
      end
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
    for (int m = 0; m < NM; m++)
      if (dmask[m % ND]) exp_st[m] = exp_nx[m];  // R11 owner mapping
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int m = 0; m < NM; m++) begin exp_st[m] = 0; exp_nx[m] = 0; exp_rel[m] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_mods("R1 reset");
    @(negedge clk);
    peek(OFF_BUSY, v);  chk(v, 0, "R1 busy");
    peek(OFF_DSTAT, v); chk(v, 0, "R1 dom0");
    peek(OFF_DSTAT + 12'd4, v); chk(v, 0, "R1 dom1");
    bus_sel = 1'b0;

    // sweep states and release bits across modules
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 2; r++) begin
        for (int m = 0; m < NM; m++) write_ctl(m, (s + m) % 4, r ^ (m & 1), 1'b0);
        check_mods("R2 before go");          // R2, R7 immediate release
        run_go(32'h1, 1'b0);
        check_mods("R5 dom0 only");           // R5, R11
        run_go(32'h2, (s == 1));              // R8 inject on one pass
        check_mods("R4 dom1");
      end
    end

    // R3 zero bits start nothing
    write_ctl(1, 2, 1, 1'b0);
    wr(OFF_GO, 32'h0);
    @(negedge clk); peek(OFF_BUSY, v); chk(v, 0, "R3 zero mask");
    bus_sel = 1'b0;

    // R4 code above 3, both domains together, R10 readback
    write_ctl(0, 37, 1, 1'b1);
    @(negedge clk);
    peek(OFF_MCTL, v); chk(v, 32'h8000_0125, "R10 ctl readback");
    peek(12'h7F0, v);  chk(v, 0, "R10 unmapped");
    peek(OFF_MSTAT + 12'(4*NM), v); chk(v, 0, "R10 past last module");
    bus_sel = 1'b0;
    run_go(32'h3, 1'b1);
    check_mods("R4 code 37");

    // R9 domain power
    wr(OFF_DCTL, 32'h1);
    run_go(32'h1, 1'b0);
    @(negedge clk);
    peek(OFF_DSTAT, v); chk(v, 1, "R9 dom0 on");
    peek(OFF_DSTAT + 12'd4, v); chk(v, 0, "R9 dom1 still off");
    bus_sel = 1'b0;
    wr(OFF_DCTL + 12'd4, 32'h1);
    @(negedge clk);
    peek(OFF_DSTAT + 12'd4, v); chk(v, 0, "R9 dom1 waits for go");
    bus_sel = 1'b0;
    run_go(32'h2, 1'b0);
    @(negedge clk);
    peek(OFF_DSTAT + 12'd4, v); chk(v, 1, "R9 dom1 on");
    bus_sel = 1'b0;
    wr(OFF_DCTL, 32'h0);
    run_go(32'h1, 1'b0);
    @(negedge clk);
    peek(OFF_DSTAT, v); chk(v, 0, "R9 dom0 off");
    bus_sel = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule